// File: doc/BRIEF.md
# Fixed Segment Address Translator

This block turns a 64-bit virtual address into a physical address for the parts of a 64-bit kernel address space that need no page table. The two top address bits choose one of four regions. The direct-physical region passes its low 59 bits straight through. The kernel region holds two 512 MB compatibility windows, one cached and one uncached, which are reached through a sign-extended 32-bit address. Every region that would need a translation lookaside buffer reports an address error and does no lookup.

A caller presents an address together with a valid strobe. With the default configuration the result comes back one clock later as a physical address, an ok flag and an error flag. A parameter removes the output register, which makes the path purely combinational. The block does not check privilege and keeps no cache attributes.

Top module: `fixseg_xlate`

## Requirements
- R1: While the synchronous active-high reset `rst` is high at a clock edge, the registered outputs are cleared to `paddr`=0, `xl_ok`=0 and `xl_err`=0. This holds even if `in_valid` is high.
- R2: With the registered stage (REG_OUT=1), the result for an address appears on the outputs one clock after the edge at which `in_valid` was high. A cycle in which `in_valid` is low gives `xl_ok`=0, `xl_err`=0 and `paddr`=0 one clock later.
- R3: When vaddr[63:62]=2'b10, the result is `xl_ok`=1 and `paddr` = vaddr[58:0] zero-extended to 64 bits.
- R4: When vaddr[63:62]=2'b10, vaddr[61:59] have no effect on the result. Two addresses that differ only in those bits give the same `paddr`.
- R5: When vaddr[63:62]=2'b11, vaddr[61:31] are all ones and vaddr[30:29] is 2'b00 or 2'b01, the result is `xl_ok`=1 and `paddr` = vaddr[28:0] zero-extended to 64 bits.
- R6: When vaddr[63:62]=2'b11, vaddr[61:31] are all ones and vaddr[30:29] is 2'b10 or 2'b11, the result is `xl_err`=1.
- R7: When vaddr[63:62]=2'b11 and vaddr[61:31] are not all ones, the result is `xl_err`=1.
- R8: When vaddr[63:62] is 2'b01 or 2'b00, the result is `xl_err`=1.
- R9: Whenever `xl_err`=1, `paddr`=0 and `xl_ok`=0. For every valid request, exactly one of `xl_ok` and `xl_err` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The address on `vaddr` is to be translated |
| vaddr | input | 64 | Virtual address |
| paddr | output | 64 | Physical address, zero when there is an error or no request |
| xl_ok | output | 1 | Translation succeeded |
| xl_err | output | 1 | Address error (mapped or reserved segment) |

## Verification
On every cycle the assertions check four things. An error always comes with a zero address and no ok. A valid request yields exactly one flag a clock later. Any user or supervisor address faults. A direct-physical address comes back as its low 59 bits. Only the bench's scenarios show the compatibility window decoding: the two accepted and two rejected cases of bits 30:29, and an all-ones pattern in bits 61:31 that is broken. The bench also shows that the cache-mode bits of the direct region do not change the result, and that reset clears an output even while a request is held.

// File: rtl/fixseg_pkg.sv
package fixseg_pkg;
  localparam int VA_W        = 64;
  localparam int DIRECT_BITS = 59;
  localparam int WIN_BITS    = 29;
  localparam int WIN_SEL_LO  = WIN_BITS;
  localparam int WIN_ONES_LO = WIN_BITS + 2;
  localparam int WIN_ONES_HI = VA_W - 3;

  typedef enum logic [1:0] {
    RGN_USER   = 2'b00,
    RGN_SUPER  = 2'b01,
    RGN_DIRECT = 2'b10,
    RGN_KERNEL = 2'b11
  } region_e;

  typedef struct packed {
    logic            ok;
    logic            err;
    logic [VA_W-1:0] pa;
  } xlate_s;

  function automatic region_e region_of(input logic [VA_W-1:0] va);
    return region_e'(va[VA_W-1 -: 2]);
  endfunction

  function automatic logic window_ones(input logic [VA_W-1:0] va);
    return &va[WIN_ONES_HI:WIN_ONES_LO];
  endfunction

  function automatic logic [1:0] window_sel(input logic [VA_W-1:0] va);
    return va[WIN_SEL_LO +: 2];
  endfunction

  function automatic logic [VA_W-1:0] direct_pa(input logic [VA_W-1:0] va);
    return {{(VA_W-DIRECT_BITS){1'b0}}, va[DIRECT_BITS-1:0]};
  endfunction

  function automatic logic [VA_W-1:0] window_pa(input logic [VA_W-1:0] va);
    return {{(VA_W-WIN_BITS){1'b0}}, va[WIN_BITS-1:0]};
  endfunction
endpackage

// File: rtl/fixseg_region_dec.sv
module fixseg_region_dec
  import fixseg_pkg::*;
(
  input  logic [VA_W-1:0] va,
  output region_e         region,
  output logic            win_ones,
  output logic [1:0]      win_sel
);
  always_comb begin
    region   = region_of(va);
    win_ones = window_ones(va);
    win_sel  = window_sel(va);
  end
endmodule

// File: rtl/fixseg_map.sv
module fixseg_map
  import fixseg_pkg::*;
(
  input  logic            valid,
  input  logic [VA_W-1:0] va,
  input  region_e         region,
  input  logic            win_ones,
  input  logic [1:0]      win_sel,
  output logic            hit_direct,
  output logic            hit_window,
  output logic            fault,
  output xlate_s          result
);
  logic win_unmapped;

  always_comb begin
    // selector values 00 and 01 are the cached and uncached windows
    win_unmapped = win_ones && !win_sel[1];
    hit_direct   = valid && (region == RGN_DIRECT);
    hit_window   = valid && (region == RGN_KERNEL) && win_unmapped;
    fault        = valid && !hit_direct && !hit_window;
  end

  always_comb begin
    result = '0;
    if (hit_direct) begin
      result.ok = 1'b1;
      result.pa = direct_pa(va);
    end else if (hit_window) begin
      result.ok = 1'b1;
      result.pa = window_pa(va);
    end else if (fault) begin
      result.err = 1'b1;
    end
  end
endmodule

// File: rtl/fixseg_out_stage.sv
module fixseg_out_stage
  import fixseg_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic   clk,
  input  logic   rst,
  input  xlate_s d,
  output xlate_s q
);
  generate
    if (REG_OUT) begin : g_reg
      xlate_s q_r;
      always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= d;
      end
      assign q = q_r;

      // R1
      reset_clear_chk: assert property (@(posedge clk) rst |=> (q == '0));
    end else begin : g_comb
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/fixseg_xlate.sv
module fixseg_xlate
  import fixseg_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [VA_W-1:0] vaddr,
  output logic [VA_W-1:0] paddr,
  output logic            xl_ok,
  output logic            xl_err
);
  region_e    region;
  logic       win_ones;
  logic [1:0] win_sel;
  logic       hit_direct, hit_window, fault;
  xlate_s     comb_res, out_res;

  fixseg_region_dec u_dec (
    .va(vaddr), .region(region), .win_ones(win_ones), .win_sel(win_sel)
  );

  fixseg_map u_map (
    .valid(in_valid), .va(vaddr), .region(region), .win_ones(win_ones),
    .win_sel(win_sel), .hit_direct(hit_direct), .hit_window(hit_window),
    .fault(fault), .result(comb_res)
  );

  fixseg_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst(rst), .d(comb_res), .q(out_res)
  );

  assign paddr  = out_res.pa;
  assign xl_ok  = out_res.ok;
  assign xl_err = out_res.err;

  // R9
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    xl_err |-> (paddr == '0) && !xl_ok);

  // R9
  hit_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_direct, hit_window, fault}));

  generate
    if (REG_OUT) begin : g_reg_chk
      // R2
      one_flag_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (xl_ok != xl_err));
      // R2
      idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !xl_ok && !xl_err && (paddr == '0));
      // R8
      mapped_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !vaddr[VA_W-1]) |=> xl_err);
      // R3
      direct_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vaddr[VA_W-1 -: 2] == 2'b10) |=>
        xl_ok && (paddr[DIRECT_BITS-1:0] == $past(vaddr[DIRECT_BITS-1:0]))
        && (paddr[VA_W-1:DIRECT_BITS] == '0));
    end
  endgenerate
endmodule

// File: tb/test_fixseg_xlate.sv
module test_fixseg_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] vaddr = '0;
  logic [63:0] paddr;
  logic        xl_ok, xl_err;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fixseg_xlate i_fixseg_xlate (
    .clk(clk), .rst(rst), .in_valid(in_valid), .vaddr(vaddr),
    .paddr(paddr), .xl_ok(xl_ok), .xl_err(xl_err)
  );

  task automatic check(input string tag, input logic eok, input logic eerr,
                       input logic [63:0] epa);
    compared++;
    if (xl_ok !== eok || xl_err !== eerr || paddr !== epa) begin
      mismatched++;
      $display("FAIL %s: got ok=%b err=%b pa=%h, expected ok=%b err=%b pa=%h",
               tag, xl_ok, xl_err, paddr, eok, eerr, epa);
    end
  endtask

  // drive one request at a falling edge, sample at the next falling edge
  task automatic xlate(input logic [63:0] va);
    @(negedge clk);
    in_valid = 1'b1;
    vaddr    = va;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    in_valid = 1'b1;
    vaddr    = 64'h8000_0000_0000_0042;
    @(negedge clk);
    check("R1 held reset", 1'b0, 1'b0, 64'h0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_latency();
    xlate(64'h8000_0000_0000_0ABC);
    check("R2 result one clock later", 1'b1, 1'b0, 64'h0000_0000_0000_0ABC);
    @(negedge clk);
    check("R2 idle cycle clears", 1'b0, 1'b0, 64'h0);
  endtask

  task automatic t_direct();
    logic [63:0] pa0;
    xlate(64'h8123_4567_89AB_CDEF);
    check("R3 direct region", 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF);
    pa0 = paddr;
    xlate(64'hB923_4567_89AB_CDEF);
    check("R4 cache mode 111", 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF);
    compared++;
    if (paddr !== pa0) begin
      mismatched++;
      $display("FAIL R4 same pa: got %h, expected %h", paddr, pa0);
    end
    xlate(64'hA123_4567_89AB_CDEF);
    check("R4 cache mode 100", 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_window();
    xlate(64'hFFFF_FFFF_9ABC_DEF0);
    check("R5 window sel 00", 1'b1, 1'b0, 64'h0000_0000_1ABC_DEF0);
    xlate(64'hFFFF_FFFF_BFFF_FFFF);
    check("R5 window sel 01", 1'b1, 1'b0, 64'h0000_0000_1FFF_FFFF);
    xlate(64'hFFFF_FFFF_C000_1000);
    check("R6 window sel 10", 1'b0, 1'b1, 64'h0);
    xlate(64'hFFFF_FFFF_E000_1000);
    check("R6 window sel 11", 1'b0, 1'b1, 64'h0);
  endtask

  task automatic t_kernel_mapped();
    xlate(64'hFFFF_FFFF_7FFF_FFFF);
    check("R7 bit31 clear", 1'b0, 1'b1, 64'h0);
    xlate(64'hC000_0000_8000_0000);
    check("R7 upper bits clear", 1'b0, 1'b1, 64'h0);
  endtask

  task automatic t_user_super();
    xlate(64'h4000_0000_0000_1000);
    check("R8 supervisor region", 1'b0, 1'b1, 64'h0);
    xlate(64'h0000_0000_0000_1000);
    check("R8 user region", 1'b0, 1'b1, 64'h0);
    xlate(64'h7FFF_FFFF_FFFF_FFFF);
    check("R9 error zero pa", 1'b0, 1'b1, 64'h0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_latency();
        t_direct();
        t_window();
        t_kernel_mapped();
        t_user_super();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          compared++;
          mismatched++;
          $display("FAIL watchdog: got timeout, expected completion");
        end
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule